// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector with Spike Filter

This block sits behind the raw clock and data pins of a two-wire serial bus. It turns them into clean levels in the system clock domain. Each line passes through a synchronizer and then a digital spike filter. The filter accepts a new level only after it has held steady for a set number of system clocks, so short glitches never reach the logic that follows.

From the filtered levels the block produces single-cycle strobes for clock rising and falling edges and for the bus start and stop conditions. It also keeps a bus-busy flag. Slave logic uses the strobes to shift bits in and out and to track transactions.

The block also times its own data output. It counts how long the filtered bus clock has been low. It issues a transmit-enable strobe, and holds a window level, once that low time has reached a programmed delay. This keeps the slave's own data changes clear of the clock's falling edge, where they could otherwise be read as a start or stop condition.

Top module: `twb_cond_detect`

## Requirements
- R1: While reset is asserted and right after it, `scl_q` and `sda_q` are 1, `busy` is 0 and every strobe is 0.
- R2: A filtered line takes a new level only after its synchronized input has held that level for FILT_N consecutive clocks. A pulse shorter than FILT_N clocks leaves the filtered level and all strobes unchanged.
- R3: `scl_rise_p` and `scl_fall_p` each pulse exactly once for every rising or falling transition of the filtered clock line.
- R4: `start_p` pulses when filtered data falls from 1 to 0 while filtered clock is 1 in both the current and the previous cycle.
- R5: `stop_p` pulses when filtered data rises from 0 to 1 while filtered clock is 1 in both the current and the previous cycle.
- R6: A data change while the filtered clock is 0 gives no start or stop. A data change in the same cycle as a clock change also gives none.
- R7: `busy` is set in the cycle after `start_p` and cleared in the cycle after `stop_p`. A repeated start leaves it set, and it changes at no other time.
- R8: If the filtered clock stays low long enough, `tx_ok_p` pulses exactly TX_DLY-1 cycles after `scl_fall_p`. If the clock rises before then, there is no pulse in that low phase.
- R9: `tx_window` is 1 from the `tx_ok_p` cycle until the filtered clock rises, and 0 whenever the filtered clock is 1.
- R10: Every strobe is one clock wide, and at most one of `start_p`, `stop_p`, `scl_rise_p`, `scl_fall_p` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_raw | input | 1 | Raw bus clock line |
| sda_raw | input | 1 | Raw bus data line |
| scl_q | output | 1 | Filtered bus clock level |
| sda_q | output | 1 | Filtered bus data level |
| scl_rise_p | output | 1 | Filtered clock rising-edge strobe |
| scl_fall_p | output | 1 | Filtered clock falling-edge strobe |
| start_p | output | 1 | Start condition strobe |
| stop_p | output | 1 | Stop condition strobe |
| busy | output | 1 | Bus busy between start and stop |
| tx_ok_p | output | 1 | Clock has been low for TX_DLY cycles |
| tx_window | output | 1 | Data output may change now |

## Verification
The bench applies several kinds of stimulus:
- Glitches one clock shorter than the filter length, on each line. These must vanish entirely.
- A data pulse exactly at the filter length. This must produce a start followed by a stop.
- Clock and data toggled in the same cycle. This separates a real condition from a data change that merely coincides with a clock edge.
- A full serial transfer with a repeated start, which shows how `busy` behaves across nested starts.
- A clock low phase that is too short for the transmit delay, compared against normal long phases. This shows the transmit strobe is tied to the measured low time.

// File: rtl/twb_cond_detect.sv
module twb_cond_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_N      = 3,
  parameter int TX_DLY      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise_p,
  output logic scl_fall_p,
  output logic start_p,
  output logic stop_p,
  output logic busy,
  output logic tx_ok_p,
  output logic tx_window
);

  localparam int FW = $clog2(FILT_N + 1);
  localparam int TW = $clog2(TX_DLY + 1);

  logic [1:0] raw_in;
  logic [1:0] sync_o;
  logic [1:0] filt;
  logic [1:0] filt_d;
  logic [TW-1:0] tcnt;

  assign raw_in = {sda_raw, scl_raw};

  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [SYNC_STAGES-1:0] sh;
    logic [FW-1:0] cnt;
    logic f;

    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[SYNC_STAGES-2:0], raw_in[i]};
    end

    assign sync_o[i] = sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        f   <= 1'b1;
      end else if (sync_o[i] == f) begin
        cnt <= '0;
      end else if (cnt == FW'(FILT_N - 1)) begin
        f   <= sync_o[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign filt[i] = f;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) filt_d <= 2'b11;
    else        filt_d <= filt;
  end

  assign scl_q = filt[0];
  assign sda_q = filt[1];

  assign scl_rise_p = filt[0] & ~filt_d[0];
  assign scl_fall_p = ~filt[0] & filt_d[0];
  assign start_p    = filt[0] & filt_d[0] & filt_d[1] & ~filt[1];
  assign stop_p     = filt[0] & filt_d[0] & ~filt_d[1] & filt[1];

  always_ff @(posedge clk) begin
    if (!rst_n)       busy <= 1'b0;
    else if (start_p) busy <= 1'b1;
    else if (stop_p)  busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || filt[0])      tcnt <= '0;
    else if (tcnt != TW'(TX_DLY)) tcnt <= tcnt + 1'b1;
  end

  assign tx_ok_p   = ~filt[0] & (tcnt == TW'(TX_DLY - 1));
  assign tx_window = ~filt[0] & (tcnt >= TW'(TX_DLY - 1));

  // R2
  scl_filt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q != $past(scl_q)) |-> ($past(sync_o[0]) == scl_q));
  // R2
  sda_filt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_q != $past(sda_q)) |-> ($past(sync_o[1]) == sda_q));
  // R7
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> busy);
  // R7
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_p && !stop_p) |=> $stable(busy));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_p, stop_p, scl_rise_p, scl_fall_p}));
  // R10
  rise_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_p |=> !scl_rise_p);
  // R10
  fall_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_p |=> !scl_fall_p);
  // R8
  txok_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok_p |=> (!tx_ok_p && (tx_window || scl_rise_p)));
  // R9
  win_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_q |-> !tx_window);

endmodule

// File: tb/sim_twb_cond_detect.sv
module sim_twb_cond_detect;
  localparam int FILT_N = 3;
  localparam int TX_DLY = 8;
  localparam int EV_START = 0, EV_STOP = 1, EV_RISE = 2, EV_FALL = 3, EV_TXOK = 4;

  logic clk = 0, rst_n = 0, scl_r = 1, sda_r = 1;
  logic scl_q, sda_q, scl_rise_p, scl_fall_p, start_p, stop_p, busy, tx_ok_p, tx_window;
  int checks = 0, fails = 0, cyc = 0, fall_cyc = 0;
  bit fin = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  twb_cond_detect #(.SYNC_STAGES(2), .FILT_N(FILT_N), .TX_DLY(TX_DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_r), .sda_raw(sda_r),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise_p(scl_rise_p), .scl_fall_p(scl_fall_p),
    .start_p(start_p), .stop_p(stop_p), .busy(busy), .tx_ok_p(tx_ok_p), .tx_window(tx_window));

  function automatic string req_of(int e);
    case (e)
      EV_START: return "R4";
      EV_STOP:  return "R5";
      EV_TXOK:  return "R8";
      default:  return "R3";
    endcase
  endfunction

  task automatic got(int e);
    int x;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL %s unexpected event: actual %0d expected none", req_of(e), e);
    end else begin
      x = exp_q.pop_front();
      if (x != e) begin
        fails++;
        $display("FAIL %s event order: actual %0d expected %0d", req_of(e), e, x);
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !fin) begin
      if (start_p) got(EV_START);
      if (stop_p) got(EV_STOP);
      if (scl_rise_p) got(EV_RISE);
      if (scl_fall_p) begin got(EV_FALL); fall_cyc = cyc; end
      if (tx_ok_p) begin
        got(EV_TXOK);
        checks++;
        if (cyc - fall_cyc != TX_DLY - 1) begin
          fails++;
          $display("FAIL R8 delay: actual %0d expected %0d", cyc - fall_cyc, TX_DLY - 1);
        end
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(logic b);
    exp_q.push_back(EV_FALL);
    exp_q.push_back(EV_TXOK);
    scl_r = 0;
    wt(3);
    sda_r = b;
    wt(17);
    chk("R9 window low phase", tx_window, 1'b1);
    chk("R2 data level", sda_q, b);
    exp_q.push_back(EV_RISE);
    scl_r = 1;
    wt(20);
    chk("R9 window high phase", tx_window, 1'b0);
    chk("R7 busy mid transfer", busy, 1'b1);
  endtask

  task automatic finish_run();
    fin = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wt(5);
    // R1 reset state
    chk("R1 scl_q", scl_q, 1'b1);
    chk("R1 sda_q", sda_q, 1'b1);
    chk("R1 busy", busy, 1'b0);
    chk("R1 strobes", start_p | stop_p | scl_rise_p | scl_fall_p | tx_ok_p, 1'b0);
    rst_n = 1;
    wt(10);
    chk("R1 after release", scl_q & sda_q & ~busy, 1'b1);

    // R2 short glitches are dropped
    scl_r = 0; wt(FILT_N - 1); scl_r = 1; wt(15);
    chk("R2 scl glitch", scl_q, 1'b1);
    sda_r = 0; wt(FILT_N - 1); sda_r = 1; wt(15);
    chk("R2 sda glitch", busy, 1'b0);

    // R2 pulse of exactly FILT_N passes: start then stop
    exp_q.push_back(EV_START);
    exp_q.push_back(EV_STOP);
    sda_r = 0; wt(FILT_N); sda_r = 1; wt(15);
    chk("R7 busy after short frame", busy, 1'b0);

    // R6 simultaneous clock and data changes
    exp_q.push_back(EV_FALL);
    exp_q.push_back(EV_TXOK);
    scl_r = 0; sda_r = 0; wt(20);
    chk("R6 no start on joint fall", busy, 1'b0);
    exp_q.push_back(EV_RISE);
    scl_r = 1; sda_r = 1; wt(20);
    chk("R6 no stop on joint rise", busy, 1'b0);

    // R4 start, R7 busy
    exp_q.push_back(EV_START);
    sda_r = 0; wt(20);
    chk("R7 busy after start", busy, 1'b1);
    chk("R2 sda low", sda_q, 1'b0);

    // R6 data changes while clock low only
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    send_bit(0); send_bit(0); send_bit(1); send_bit(0);

    // R8 short low phase: no transmit strobe
    exp_q.push_back(EV_FALL);
    exp_q.push_back(EV_RISE);
    scl_r = 0; wt(5); scl_r = 1; wt(20);
    chk("R8 no window after short low", tx_window, 1'b0);

    // R7 repeated start keeps busy
    send_bit(1);
    exp_q.push_back(EV_START);
    sda_r = 0; wt(20);
    chk("R7 busy after repeated start", busy, 1'b1);

    // R5 stop clears busy
    send_bit(0);
    exp_q.push_back(EV_STOP);
    sda_r = 1; wt(20);
    chk("R7 busy after stop", busy, 1'b0);

    wt(20);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3 missing events: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule